// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 32-bit non-PAE paging. It reads a directory entry from memory and, unless that entry maps a large page, a second-level table entry. Reads and write-backs go through one memory port that uses request/grant handshakes, with a separate read-response strobe. The walker then reports the physical address, whether a 4 MB page was used, and the combined user and read/write rights. If the walk cannot complete, it instead reports a fault with a cause code.

A caller presents one request at a time and holds it while `req_ready` is low. The table base and the large-page enable are sampled together with the request. The walker keeps the in-memory tables coherent by writing back accessed and dirty flags. Permission policy and translation caching are left to neighbouring blocks.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at address `{cr3[31:12], vaddr[31:22], 2'b00}`. The low 12 bits of `cr3` are ignored.
- R2: For a 4 KB walk, the table entry is read at `{dir[31:12], vaddr[21:12], 2'b00}`, where `dir` is the directory entry.
- R3: A clear bit 0 (present) in the directory entry or in the table entry ends the walk with `fault`=1 and `fault_cause`=1. No write-back of that entry occurs.
- R4: The directory entry maps a 4 MB page only when its bit 7 is set and `pse_en` was 1 at acceptance. Otherwise the entry is used as a pointer to a page table, whatever bit 7 holds.
- R5: For a 4 MB page, `pa` = `{dir[20:13], dir[31:22], vaddr[21:0]}` and `big_page`=1.
- R6: For a 4 MB page, a set bit 21 in the directory entry gives `fault`=1 with `fault_cause`=2.
- R7: For 4 KB pages, `perm_user` is the AND of bit 2 of both entries and `perm_rw` is the AND of bit 1 of both entries. For 4 MB pages, both come from the directory entry alone.
- R8: During a 4 KB walk, a directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table read. A directory entry with bit 5 already set is not written.
- R9: On a successful walk, the final entry is written back exactly once if needed. The write sets bit 5 when it is clear, and sets bit 6 (dirty) when `req_write`=1 and bit 6 is clear. If neither change is needed, there is no write.
- R10: For 4 KB pages, `pa` = `{8'h00, tbl[31:12], vaddr[11:0]}` and `big_page`=0.
- R11: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_gnt`. `req_ready` is high only when no walk is in progress, and a read's data is taken only from a `mem_rvalid` that follows its grant.
- R12: After reset, `req_ready`=1, `mem_req`=0 and `done`=0. Each walk ends with `done` high for exactly one cycle, with `fault`, `fault_cause`, `pa`, `big_page` and the rights valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a store (drives dirty update) |
| cr3 | input | 32 | Directory base, bits 31:12 used |
| pse_en | input | 1 | Large-page enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 none, 1 not present, 2 reserved bit |
| pa | output | 40 | Physical address |
| big_page | output | 1 | Mapping is a 4 MB page |
| perm_user | output | 1 | Combined user right |
| perm_rw | output | 1 | Combined write right |

## Verification
The walker is driven with randomly generated directory and table entries. These random entries mix present and absent entries, the size bit with and without the enable, reserved bit 21, and both states of the accessed and dirty flags. Together they separate the large-page path from the table path and the not-present fault from the reserved-bit fault. They also separate walks that need zero, one or two write-backs.

Grants arrive after random delays, which shows that requests hold steady while they wait. Directed cases cover the remaining corners: an all-ones address, a `cr3` with junk in its low bits, a large page with a distinctive high-address byte, and a store to an entry that is already accessed and dirty. After each walk, the memory contents and the write count are compared with an independent model.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic [31:0] cr3,
  input  logic        pse_en,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_cause,
  output logic [39:0] pa,
  output logic        big_page,
  output logic        perm_user,
  output logic        perm_rw
);
  localparam int BP = 0, BRW = 1, BUS = 2, BA = 5, BD = 6, BPS = 7, BRSV = 21;
  localparam logic [1:0] C_NP = 2'd1, C_RSV = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_WB_DIR, S_RD_TBL, S_WB_FIN, S_DONE, S_FAULT} st_t;
  st_t st;

  logic        issued, wr_q, pse_q, big_q;
  logic [31:0] va_q, pde_q, pte_q;
  logic [19:0] base_q;
  logic [1:0]  cause_q;

  wire [31:0] dir_addr = {base_q, va_q[31:22], 2'b00};
  wire [31:0] tbl_addr = {pde_q[31:12], va_q[21:12], 2'b00};
  wire [31:0] fin      = big_q ? pde_q : pte_q;
  wire [31:0] fin_addr = big_q ? dir_addr : tbl_addr;
  wire [31:0] fin_new  = fin | (32'd1 << BA) | (wr_q ? (32'd1 << BD) : 32'd0);
  wire        rd_st    = (st == S_RD_DIR) || (st == S_RD_TBL);
  wire        got      = issued && mem_rvalid;

  function automatic logic needs_wb(input logic [31:0] e, input logic w);
    return !e[BA] || (w && !e[BD]);
  endfunction

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (rd_st && !issued) || (st == S_WB_DIR) || (st == S_WB_FIN);
  assign mem_we    = (st == S_WB_DIR) || (st == S_WB_FIN);
  assign mem_addr  = (st == S_RD_DIR || st == S_WB_DIR) ? dir_addr :
                     (st == S_RD_TBL) ? tbl_addr : fin_addr;
  assign mem_wdata = (st == S_WB_DIR) ? (pde_q | (32'd1 << BA)) : fin_new;

  assign done        = (st == S_DONE) || (st == S_FAULT);
  assign fault       = (st == S_FAULT);
  assign fault_cause = fault ? cause_q : 2'd0;
  assign big_page    = big_q;
  assign pa          = big_q ? {pde_q[20:13], pde_q[31:22], va_q[21:0]}
                             : {8'h00, pte_q[31:12], va_q[11:0]};
  assign perm_user   = big_q ? pde_q[BUS] : (pde_q[BUS] & pte_q[BUS]);
  assign perm_rw     = big_q ? pde_q[BRW] : (pde_q[BRW] & pte_q[BRW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      issued  <= 1'b0;
      wr_q    <= 1'b0;
      pse_q   <= 1'b0;
      big_q   <= 1'b0;
      va_q    <= '0;
      pde_q   <= '0;
      pte_q   <= '0;
      base_q  <= '0;
      cause_q <= '0;
    end else begin
      if (rd_st && !issued && mem_gnt) issued <= 1'b1;
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          base_q <= cr3[31:12];
          pse_q  <= pse_en;
          big_q  <= 1'b0;
          issued <= 1'b0;
          st     <= S_RD_DIR;
        end
        S_RD_DIR: if (got) begin
          issued <= 1'b0;
          pde_q  <= mem_rdata;
          if (!mem_rdata[BP]) begin
            cause_q <= C_NP;
            st      <= S_FAULT;
          end else if (mem_rdata[BPS] && pse_q) begin
            big_q <= 1'b1;
            if (mem_rdata[BRSV]) begin
              cause_q <= C_RSV;
              st      <= S_FAULT;
            end else begin
              st <= needs_wb(mem_rdata, wr_q) ? S_WB_FIN : S_DONE;
            end
          end else begin
            st <= mem_rdata[BA] ? S_RD_TBL : S_WB_DIR;
          end
        end
        S_WB_DIR: if (mem_gnt) st <= S_RD_TBL;
        S_RD_TBL: if (got) begin
          issued <= 1'b0;
          pte_q  <= mem_rdata;
          if (!mem_rdata[BP]) begin
            cause_q <= C_NP;
            st      <= S_FAULT;
          end else begin
            st <= needs_wb(mem_rdata, wr_q) ? S_WB_FIN : S_DONE;
          end
        end
        S_WB_FIN: if (mem_gnt) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic [31:0] cr3,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_cause,
  input logic [39:0] pa,
  input logic        big_page
);
  logic [31:0] va_c, cr3_c;
  logic        first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_c  <= '0;
      cr3_c <= '0;
      first <= 1'b0;
    end else if (req_valid && req_ready) begin
      va_c  <= req_vaddr;
      cr3_c <= cr3;
      first <= 1'b1;
    end else if (mem_req && mem_gnt) begin
      first <= 1'b0;
    end
  end

  AST_FIRST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    first && mem_req |-> !mem_we && mem_addr == {cr3_c[31:12], va_c[31:22], 2'b00}); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !done); // R11
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> (fault_cause == 2'd1 || fault_cause == 2'd2)); // R3
  AST_SMALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> pa[11:0] == va_c[11:0]); // R10
  AST_BIG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && big_page |-> pa[21:0] == va_c[21:0]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[5]); // R9
endmodule

bind pt_walker pt_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .cr3(cr3), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .done(done),
  .fault(fault), .fault_cause(fault_cause), .pa(pa), .big_page(big_page)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, pse_en = 1'b0;
  logic [31:0] req_vaddr = '0, cr3 = '0;
  logic        req_ready, mem_req, mem_we, done, fault, big_page, perm_user, perm_rw;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  fault_cause;
  logic [39:0] pa;
  logic        gnt_en = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  wire         mem_gnt = mem_req & gnt_en;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .cr3(cr3), .pse_en(pse_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_cause(fault_cause), .pa(pa),
    .big_page(big_page), .perm_user(perm_user), .perm_rw(perm_rw)
  );

  logic [31:0] mem [logic [31:0]];
  int wr_cnt = 0;
  int checks = 0, failures = 0;
  int cycles = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
      end
    end
  end

  always @(negedge clk) gnt_en <= ($urandom_range(0, 99) < 60);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Independent model plus stimulus and checks for one walk
  task automatic walk(input logic [31:0] va, input logic w, input logic [31:0] c3, input logic pse);
    logic [31:0] da, ta, d, t, e, fa, nf, exp_d, exp_t;
    logic        e_fault, e_big, e_u, e_rw;
    logic [1:0]  e_cause;
    logic [39:0] e_pa;
    int          e_wr;
    int          n;
    e_fault = 0; e_cause = 0; e_big = 0; e_u = 0; e_rw = 0; e_pa = '0; e_wr = 0;
    da = {c3[31:12], va[31:22], 2'b00};
    d = rd(da); exp_d = d;
    ta = {d[31:12], va[21:12], 2'b00};
    t = rd(ta); exp_t = t;
    e = d; fa = da;
    if (!d[0]) begin
      e_fault = 1; e_cause = 2'd1;
    end else if (d[7] && pse) begin
      e_big = 1;
      if (d[21]) begin e_fault = 1; e_cause = 2'd2; end
      else begin
        e_pa = {d[20:13], d[31:22], va[21:0]}; e_u = d[2]; e_rw = d[1];
      end
    end else begin
      if (!d[5]) begin e_wr++; exp_d = d | 32'h20; end
      if (!t[0]) begin e_fault = 1; e_cause = 2'd1; end
      else begin
        e = t; fa = ta;
        e_pa = {8'h00, t[31:12], va[11:0]}; e_u = d[2] & t[2]; e_rw = d[1] & t[1];
      end
    end
    if (!e_fault) begin
      nf = e | 32'h20 | (w ? 32'h40 : 32'h0);
      if (nf != e) begin
        e_wr++;
        if (fa == da) exp_d = nf; else exp_t = nf;
      end
    end
    wr_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; cr3 = c3; pse_en = pse;
    @(negedge clk);
    req_valid = 0; req_vaddr = $urandom; cr3 = $urandom; pse_en = $urandom;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done, "R12 walk completion", 64'(done), 64'd1);
    if (!done) return;
    chk(fault == e_fault, "R3/R6 fault flag", 64'(fault), 64'(e_fault));
    chk(fault_cause == e_cause, "R3/R6 fault cause", 64'(fault_cause), 64'(e_cause));
    if (!e_fault) begin
      chk(big_page == e_big, "R4 page size", 64'(big_page), 64'(e_big));
      chk(pa == e_pa, e_big ? "R5 large pa" : "R10 small pa", 64'(pa), 64'(e_pa));
      chk(perm_user == e_u && perm_rw == e_rw, "R7 rights",
          64'({perm_user, perm_rw}), 64'({e_u, e_rw}));
    end
    @(negedge clk);
    chk(!done && req_ready, "R12 done single pulse", 64'({done, req_ready}), 64'b01);
    chk(wr_cnt == e_wr, "R8/R9 write-back count", 64'(wr_cnt), 64'(e_wr));
    chk(rd(da) == exp_d, "R8/R9 directory entry after walk", 64'(rd(da)), 64'(exp_d));
    if (ta != da)
      chk(rd(ta) == exp_t, "R9/R3 table entry after walk", 64'(rd(ta)), 64'(exp_t));
  endtask

  initial begin
    logic [31:0] c3, va, pde, pte;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R12 reset state",
        64'({req_ready, mem_req, done}), 64'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_req && !done, "R12 idle after reset",
        64'({req_ready, mem_req, done}), 64'b100);

    // R1/R2/R10: all-ones address, junk in cr3 low bits, 4 KB store, flags clear
    mem.delete();
    mem[{20'h00100, 10'h3FF, 2'b00}] = 32'h0040_3007;
    mem[{20'h00403, 10'h3FF, 2'b00}] = 32'h1234_5007;
    walk(32'hFFFF_FFFF, 1, 32'h0010_0ABC, 1);
    // R4: size bit set but enable off, so used as table pointer
    mem.delete();
    mem[{20'h00100, 10'h001, 2'b00}] = 32'h0040_50A7;
    mem[{20'h00405, 10'h002, 2'b00}] = 32'h0ABC_D003;
    walk(32'h0040_2123, 0, 32'h0010_0000, 0);
    // R5: large page with high byte A5
    mem.delete();
    mem[{20'h00100, 10'h155, 2'b00}] = {10'h2AB, 1'b0, 8'hA5, 13'h0087};
    walk(32'h5553_4567, 1, 32'h0010_0000, 1);
    // R6: reserved bit 21 on a large page
    mem.delete();
    mem[{20'h00100, 10'h010, 2'b00}] = 32'h0320_00A7;
    walk(32'h0401_0000, 0, 32'h0010_0000, 1);
    // R3: directory not present, then table not present
    mem.delete();
    walk(32'h0800_0000, 1, 32'h0010_0000, 1);
    mem[{20'h00100, 10'h020, 2'b00}] = 32'h0040_7027;
    mem[{20'h00407, 10'h000, 2'b00}] = 32'h0000_0066;
    walk(32'h0800_0FFF, 1, 32'h0010_0000, 0);
    // R9: everything already accessed and dirty, store causes no write
    mem.delete();
    mem[{20'h00100, 10'h030, 2'b00}] = 32'h0040_8027;
    mem[{20'h00408, 10'h011, 2'b00}] = 32'h7777_7067;
    walk(32'h0C01_1ABC, 1, 32'h0010_0000, 1);
    // R9: load on accessed-clear entry sets accessed only
    mem.delete();
    mem[{20'h00100, 10'h030, 2'b00}] = 32'h0040_8027;
    mem[{20'h00408, 10'h011, 2'b00}] = 32'h7777_7005;
    walk(32'h0C01_1ABC, 0, 32'h0010_0000, 1);

    for (int i = 0; i < 400; i++) begin
      mem.delete();
      c3 = 32'h0010_0000 | ($urandom & 32'hFFF);
      va = $urandom;
      pde = $urandom;
      pde[31:20] = {11'h002, 1'b0};
      pde[21] = ($urandom_range(0, 99) < 15);
      pde[20] = 1'b0;
      pde[0] = ($urandom_range(0, 99) < 88);
      mem[{c3[31:12], va[31:22], 2'b00}] = pde;
      pte = $urandom;
      pte[0] = ($urandom_range(0, 99) < 88);
      mem[{pde[31:12], va[21:12], 2'b00}] = pte;
      walk(va, 1'($urandom), c3, 1'($urandom));
    end
    finish_run();
  end
endmodule